// File: doc/BRIEF.md
# Pointer-Addressed I2C Read-Out Slave

This block is an I2C slave that gives a bus host read access to a byte-wide register space. The space is selected by an internal 8-bit pointer that the host cannot read back. A write transaction loads the pointer from its first data byte. Any further bytes in that write are acknowledged and thrown away, and each of them moves the pointer forward by one. A read transaction returns the byte the pointer selects, MSB first. The pointer then moves forward, and reading continues for as long as the host acknowledges. The pointer stops at FFh and never wraps.

The block runs on a system clock that is much faster than SCL. It synchronises both bus lines and finds the START, STOP and SCL edges in that clock domain. It only ever pulls SDA low, through an output-enable. The pointer is presented on `reg_addr` to an external register bank, which answers combinationally on `reg_rdata`. A parameter mask marks which addresses are mapped. Unmapped addresses read as 00h.

Top module: `i2c_ptr_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and `reg_addr` is 00h. While the slave is idle it never drives SDA.
- R2: The slave pulls SDA low in the ninth bit of an address byte whose upper seven bits equal `SLV_ADDR` (default 2Bh, so 56h for write and 57h for read; bit 0 = 1 means read). Any other address gets no ACK, the rest of that transaction is ignored, and the pointer is unchanged.
- R3: In a write transaction, the first data byte after the address is loaded into the pointer. The slave ACKs every written data byte.
- R4: Every further data byte of the same write only advances the pointer by one. Its value is discarded.
- R5: Each read byte is the register the pointer selects at the moment the byte's first bit is driven, sent MSB first. The pointer advances by one after each byte is fetched.
- R6: A read goes on to the next register while the host ACKs. On a host NACK the slave releases SDA and waits for STOP or START.
- R7: The pointer saturates at FFh under both read and write advancing. It never wraps to 00h.
- R8: Reads from addresses whose bit in `MAP_MASK` is 0 return 00h and still advance the pointer. By default only 1Eh, 1Fh, 21h, 22h, 23h and 28h are mapped.
- R9: A repeated START restarts the byte count, so the next write's first data byte loads the pointer again. The pointer value is kept across it, so a read after a repeated START continues from it.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | 8 | Current pointer, register bank address |
| reg_rdata | input | 8 | Register bank data for `reg_addr` |

## Verification
The fetch of a read byte and the saturation clamp on the pointer fall in the same clock when a byte is fetched at FFh. The fetch uses the old pointer while the advance is suppressed. This is provoked by setting the pointer to FEh and then reading four bytes, and separately by writing extra bytes from FDh. It is judged by `reg_addr` staying at FFh and by every returned byte matching the value computed for the clamped address. A near-exhaustive sweep writes every even pointer value and reads two bytes from it. The expected data comes from an arithmetic bank model and the mapped-address mask.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_ACK,
    ST_WR,
    ST_WR_END,
    ST_RD,
    ST_MACK
  } slv_state_t;

  localparam logic [255:0] DEF_MAP =
      (256'd1 << 8'h1E) | (256'd1 << 8'h1F) | (256'd1 << 8'h21) |
      (256'd1 << 8'h22) | (256'd1 << 8'h23) | (256'd1 << 8'h28);

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_d <= scl_q[SYNC_STAGES-1];
      sda_d <= sda_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    scl_s     = scl_q[SYNC_STAGES-1];
    sda_s     = sda_q[SYNC_STAGES-1];
    scl_rise  = scl_s & ~scl_d;
    scl_fall  = ~scl_s & scl_d;
    start_det = scl_s & scl_d & sda_d & ~sda_s;
    stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  end

endmodule

// File: rtl/i2c_ptr_reg.sv
module i2c_ptr_reg #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [PTR_W-1:0] load_val,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] PTR_MAX = '1;

  logic [PTR_W-1:0] ptr_nxt;

  always_comb begin
    ptr_nxt = ptr;
    if (load)
      ptr_nxt = load_val;
    else if (step && (ptr != PTR_MAX))
      ptr_nxt = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end

  // R7: once at the top the pointer stays there unless reloaded
  a_r7_ptr_holds_max: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == PTR_MAX && !load) |=> (ptr == PTR_MAX));

  // R4: without a load the pointer moves by at most one
  a_r4_ptr_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> ((ptr == $past(ptr)) || (ptr == $past(ptr) + 1'b1)));

endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
  import i2c_ptr_pkg::*;
#(
  parameter logic [6:0]   SLV_ADDR    = 7'h2B,
  parameter int           SYNC_STAGES = 2,
  parameter int           DATA_W      = 8,
  parameter logic [255:0] MAP_MASK    = DEF_MAP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [DATA_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_rdata
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  slv_state_t        state, state_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [DATA_W-1:0] sh, sh_n;
  logic              rw, rw_n;
  logic              first, first_n;
  logic              oe_n;
  logic              ptr_load, ptr_step;
  logic [DATA_W-1:0] rd_byte;

  i2c_ptr_reg #(.PTR_W(DATA_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ptr_load),
    .step    (ptr_step),
    .load_val(sh),
    .ptr     (reg_addr)
  );

  // unmapped registers read as zero
  always_comb rd_byte = MAP_MASK[reg_addr] ? reg_rdata : '0;

  always_comb begin
    state_n  = state;
    cnt_n    = cnt;
    sh_n     = sh;
    rw_n     = rw;
    first_n  = first;
    oe_n     = sda_oe;
    ptr_load = 1'b0;
    ptr_step = 1'b0;
    if (stop_det) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      first_n = 1'b1;
      oe_n    = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR, ST_WR: if (scl_rise) begin
          sh_n  = {sh[DATA_W-2:0], sda_s};
          cnt_n = cnt + 1'b1;
          if (cnt == LAST_BIT)
            state_n = (state == ST_ADDR) ? ST_ADDR_END : ST_WR_END;
        end
        ST_ADDR_END: if (scl_fall) begin
          if (sh[DATA_W-1:1] == SLV_ADDR) begin
            rw_n    = sh[0];
            oe_n    = 1'b1;
            state_n = ST_ACK;
          end else begin
            state_n = ST_IDLE;
          end
        end
        ST_WR_END: if (scl_fall) begin
          oe_n    = 1'b1;
          state_n = ST_ACK;
          if (first) begin
            ptr_load = 1'b1;
            first_n  = 1'b0;
          end else begin
            ptr_step = 1'b1;
          end
        end
        ST_ACK: if (scl_fall) begin
          cnt_n = '0;
          if (rw) begin
            sh_n     = rd_byte;
            oe_n     = ~rd_byte[DATA_W-1];
            ptr_step = 1'b1;
            state_n  = ST_RD;
          end else begin
            oe_n    = 1'b0;
            state_n = ST_WR;
          end
        end
        ST_RD: if (scl_fall) begin
          cnt_n = cnt + 1'b1;
          if (cnt == LAST_BIT) begin
            oe_n    = 1'b0;
            state_n = ST_MACK;
          end else begin
            sh_n = {sh[DATA_W-2:0], 1'b0};
            oe_n = ~sh[DATA_W-2];
          end
        end
        ST_MACK: if (scl_rise) begin
          state_n = sda_s ? ST_IDLE : ST_ACK;
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      rw     <= 1'b0;
      first  <= 1'b1;
      sda_oe <= 1'b0;
    end else begin
      state  <= state_n;
      cnt    <= cnt_n;
      sh     <= sh_n;
      rw     <= rw_n;
      first  <= first_n;
      sda_oe <= oe_n;
    end
  end

  // R10: the data line driver only moves while the clock line is low
  a_r10_sda_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!scl_s || start_det || stop_det));

  // R1: an idle slave leaves the bus alone
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R6: the host's acknowledge slot is never driven by the slave
  a_r6_mack_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MACK) |-> !sda_oe);

  // R2: an address ACK is only driven after a full address byte
  a_r2_ack_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK && $past(state) == ST_ADDR_END) |-> sda_oe);

endmodule

// File: tb/i2c_ptr_slave_tb.sv
`timescale 1ns/1ps
module i2c_ptr_slave_tb;

  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl, m_sda_oe;
  logic dut_oe;
  logic [7:0] reg_addr, reg_rdata;
  logic sda_bus;

  int n_chk = 0;
  int n_bad = 0;
  int r10_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign sda_bus   = ~(m_sda_oe | dut_oe);
  assign reg_rdata = {reg_addr[3:0], reg_addr[7:4]} ^ 8'h5A;

  i2c_ptr_slave u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (m_scl),
    .sda_i    (sda_bus),
    .sda_oe   (dut_oe),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] exp_rd(input int a);
    logic [7:0] b;
    b = 8'(a);
    if (b inside {8'h1E, 8'h1F, 8'h21, 8'h22, 8'h23, 8'h28})
      return {b[3:0], b[7:4]} ^ 8'h5A;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda_oe = 1'b0; q();
    m_scl = 1'b1; q();
    m_sda_oe = 1'b1; q();
    m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda_oe = 1'b1; q();
    m_scl = 1'b1; q();
    m_sda_oe = 1'b0; q(); q();
  endtask

  task automatic bus_bit(input logic b, output logic s);
    m_sda_oe = ~b; q();
    m_scl = 1'b1; q();
    s = sda_bus; q();
    m_scl = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      d[i] = s;
    end
    bus_bit(~ack_it, s);
  endtask

  task automatic set_ptr(input logic [7:0] p, input string req);
    logic a;
    bus_start();
    send_byte(8'h56, a); chk({req, " addr ack"}, a, 1);
    send_byte(p, a);     chk({req, " data ack"}, a, 1);
    bus_stop();
  endtask

  // R10 monitor: the driver must not move while the bench holds SCL high
  logic prev_oe;
  always @(negedge clk) begin
    if (rst_n && m_scl && (dut_oe !== prev_oe)) r10_bad++;
    prev_oe <= dut_oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    m_scl = 1'b1; m_sda_oe = 1'b0; rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    chk("R1 reset sda_oe", dut_oe, 0);
    chk("R1 reset pointer", reg_addr, 0);
    rst_n = 1'b1;
    q();

    // R3/R5/R6: load 22h, then read two registers
    set_ptr(8'h22, "R3");
    chk("R3 pointer loaded", reg_addr, 8'h22);
    bus_start();
    send_byte(8'h57, a); chk("R2 read addr ack", a, 1);
    recv_byte(1'b1, d);  chk("R5 first read", d, exp_rd(8'h22));
    recv_byte(1'b0, d);  chk("R6 second read after ack", d, exp_rd(8'h23));
    chk("R6 sda released after nack", dut_oe, 0);
    bus_stop();
    chk("R5 pointer advanced", reg_addr, 8'h24);

    // R2: foreign addresses get no ack, pointer untouched
    bus_start();
    send_byte(8'h54, a); chk("R2 foreign write addr nack", a, 0);
    send_byte(8'h10, a); chk("R2 foreign data ignored", a, 0);
    bus_stop();
    chk("R2 pointer unchanged", reg_addr, 8'h24);
    bus_start();
    send_byte(8'h55, a); chk("R2 foreign read addr nack", a, 0);
    bus_stop();

    // R4: extra write bytes only step the pointer
    bus_start();
    send_byte(8'h56, a);
    send_byte(8'h1C, a);
    send_byte(8'hAA, a); chk("R4 extra byte acked", a, 1);
    send_byte(8'hBB, a);
    bus_stop();
    chk("R4 pointer stepped", reg_addr, 8'h1E);
    bus_start();
    send_byte(8'h57, a);
    recv_byte(1'b0, d); chk("R4 read after extras", d, exp_rd(8'h1E));
    bus_stop();

    // R7: write-side saturation
    bus_start();
    send_byte(8'h56, a);
    send_byte(8'hFD, a);
    for (int i = 0; i < 5; i++) send_byte(8'h00, a);
    bus_stop();
    chk("R7 write saturates", reg_addr, 8'hFF);

    // R7/R8: read-side saturation, unmapped reads zero
    set_ptr(8'hFE, "R7");
    bus_start();
    send_byte(8'h57, a);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, d);
      chk("R8 unmapped read", d, 0);
      chk("R7 read saturates", reg_addr, 8'hFF);
    end
    bus_stop();

    // R9: repeated start keeps the pointer and restarts the byte count
    bus_start();
    send_byte(8'h56, a);
    send_byte(8'h21, a);
    bus_start();
    send_byte(8'h57, a); chk("R9 addr ack after Sr", a, 1);
    recv_byte(1'b0, d);  chk("R9 read keeps pointer", d, exp_rd(8'h21));
    bus_start();
    send_byte(8'h56, a);
    send_byte(8'h28, a);
    chk("R9 first byte after Sr reloads", reg_addr, 8'h28);
    bus_start();
    send_byte(8'h57, a);
    recv_byte(1'b0, d);  chk("R9 read after reload", d, exp_rd(8'h28));
    bus_stop();

    // R5/R8 sweep over even pointer values
    for (int p = 0; p < 256; p += 2) begin
      set_ptr(8'(p), "R3 sweep");
      bus_start();
      send_byte(8'h57, a);
      recv_byte(1'b1, d); chk("R5 sweep byte0", d, exp_rd(p));
      recv_byte(1'b0, d); chk("R8 sweep byte1", d, exp_rd((p + 1 > 255) ? 255 : p + 1));
      bus_stop();
      chk("R7 sweep pointer", reg_addr, (p + 2 > 255) ? 255 : p + 2);
    end

    chk("R10 sda changes with scl high", r10_bad, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule